// File: doc/BRIEF.md
# Hold-Handshake Multi-Master Bus Arbiter

This block shares one bus among a parameterized set of masters (four by default). Each master raises a request line when it has bus work pending. The arbiter grants the bus to one master at a time. It moves the bus only through a polite handshake: it asks the current owner to yield, waits for that owner to acknowledge, and only then grants the next master. While a yield is pending, no master holds a grant.

Ownership is parked. A master keeps the grant while nobody else asks for the bus, even after its own request has dropped. A contender is served right away when the owner is no longer requesting. When the owner keeps requesting, a programmable time slice bounds how long it can hold out against the other masters. Among several contenders the choice rotates round-robin, starting just after the most recent grantee.

Top module: `hold_arbiter`

## Requirements
- R1: While reset is held and straight after it, no grant and no yield request is asserted, and no master owns the bus.
- R2: With no owner, a request sampled at a clock edge produces a grant to one requester after that edge, with no yield request raised to anyone.
- R3: The winner among contenders is the first requesting master after the most recent grantee, in ascending circular index order. After reset, master 0 ranks first.
- R4: An owner keeps its grant unchanged while no other master requests, whether or not its own request is still high.
- R5: When another master requests and the owner's request is low, the next cycle shows the yield request raised on the owner only, and the owner's grant removed.
- R6: While a yield request is outstanding, no grant is asserted and the yield request stays put until the yielding master's acknowledge is sampled high. Acknowledges from other masters have no effect. One cycle after the owner's acknowledge is sampled, the yield request drops and the new grant appears.
- R7: An owner that keeps requesting while another master requests holds the grant for exactly `slice_limit`+1 cycles, counted from the first cycle of its grant. In the next cycle the yield request to it is raised.
- R8: At most one grant bit and at most one yield bit are ever high, and never a grant and a yield request at the same time.
- R9: If the contenders withdraw before the owner acknowledges, the acknowledge returns the grant to the old owner when that owner is requesting. Otherwise it leaves the bus unowned, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | N_MST | Bus request, one bit per master |
| yield_ack | input | N_MST | Acknowledge from a master that it has released the bus |
| slice_limit | input | SLICE_W | Time-slice length minus one, in clocks |
| yield_req | output | N_MST | Request for a master to release the bus |
| bus_grant | output | N_MST | Bus grant, one-hot or zero |

## Verification
A corrupted owner index or round-robin pointer appears in the first grant that follows. That grant lands on the wrong bit, or the yield request lands on a master that was never granted, one cycle after the handoff decision. A wrong slice count moves the rise of the yield request by at least one cycle against the `slice_limit`+1 window, so each slice is checked at its exact edge. A stuck handshake state shows as a grant asserted during an outstanding yield, or as a yield that never clears after the acknowledge. Either appears within a cycle.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_OWNED = 2'd1,
    ST_YIELD = 2'd2
  } arb_state_e;

endpackage

// File: rtl/hold_arb_rr.sv
module hold_arb_rr #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] win
);

  // circular successor of a position, offset steps ahead
  function automatic int wrap_add(input int base, input int off);
    int s;
    s = base + off;
    if (s >= N_MST) s = s - N_MST;
    return s;
  endfunction

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int off = 1; off <= N_MST; off++) begin
      int pos;
      pos = wrap_add(int'(last), off);
      if (!found && cand[pos]) begin
        found = 1'b1;
        win   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/hold_arb_slice.sv
module hold_arb_slice #(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  logic [SLICE_W-1:0] limit,
  output logic               expired
);

  localparam logic [SLICE_W-1:0] CNT_MAX = {SLICE_W{1'b1}};

  logic [SLICE_W-1:0] cnt_q;

  function automatic logic slice_over(input logic [SLICE_W-1:0] used,
                                      input logic [SLICE_W-1:0] lim);
    return used >= lim;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (restart)                   cnt_q <= '0;
    else if (run && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && slice_over(cnt_q, limit);

endmodule

// File: rtl/hold_arb_ctrl.sv
module hold_arb_ctrl
  import hold_arb_pkg::*;
#(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] mst_req,
  input  logic [N_MST-1:0] yield_ack,
  input  logic             slice_expired,
  input  logic             pick_found,
  input  logic [IDX_W-1:0] pick_idx,
  output logic [N_MST-1:0] pick_req,
  output logic [IDX_W-1:0] owner,
  output logic             owned,
  output logic             restart,
  output logic             handoff_start,
  output logic             handoff_done,
  output logic             idle_grant,
  output logic [N_MST-1:0] yield_req,
  output logic [N_MST-1:0] bus_grant
);

  localparam logic [IDX_W-1:0] RST_LAST = IDX_W'(N_MST - 1);

  function automatic logic [N_MST-1:0] to_1h(input logic [IDX_W-1:0] idx);
    logic [N_MST-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  arb_state_e       st_q, st_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic [N_MST-1:0] own_1h;
  logic             others_req;
  logic             own_still_req;

  assign own_1h        = to_1h(own_q);
  assign others_req    = |(mst_req & ~own_1h);
  assign own_still_req = |(mst_req & own_1h);

  assign handoff_start = (st_q == ST_OWNED) && others_req &&
                         (!own_still_req || slice_expired);
  assign handoff_done  = (st_q == ST_YIELD) && (|(yield_ack & own_1h));
  assign idle_grant    = (st_q == ST_FREE) && pick_found;
  assign pick_req      = (st_q == ST_YIELD) ? (mst_req & ~own_1h) : mst_req;

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    unique case (st_q)
      ST_FREE: begin
        if (pick_found) begin
          st_d  = ST_OWNED;
          own_d = pick_idx;
        end
      end
      ST_OWNED: begin
        if (handoff_start) st_d = ST_YIELD;
      end
      ST_YIELD: begin
        if (handoff_done) begin
          if (pick_found) begin
            st_d  = ST_OWNED;
            own_d = pick_idx;
          end else if (own_still_req) begin
            st_d  = ST_OWNED;
          end else begin
            st_d  = ST_FREE;
          end
        end
      end
      default: st_d = ST_FREE;
    endcase
  end

  assign restart = (st_d == ST_OWNED) && (st_q != ST_OWNED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FREE;
      own_q <= RST_LAST;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  assign owner     = own_q;
  assign owned     = (st_q == ST_OWNED);
  assign bus_grant = (st_q == ST_OWNED) ? own_1h : '0;
  assign yield_req = (st_q == ST_YIELD) ? own_1h : '0;

endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int N_MST   = 4,
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_MST-1:0]   mst_req,
  input  logic [N_MST-1:0]   yield_ack,
  input  logic [SLICE_W-1:0] slice_limit,
  output logic [N_MST-1:0]   yield_req,
  output logic [N_MST-1:0]   bus_grant
);

  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  // internal events, named for the checker
  logic             handoff_start;
  logic             handoff_done;
  logic             idle_grant;
  logic             slice_expired;
  logic             restart;
  logic             owned;
  logic [IDX_W-1:0] owner;
  logic [N_MST-1:0] pick_req;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;

  hold_arb_rr #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rr (
    .cand  (pick_req),
    .last  (owner),
    .found (pick_found),
    .win   (pick_idx)
  );

  hold_arb_slice #(.SLICE_W(SLICE_W)) u_slice (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (owned),
    .limit   (slice_limit),
    .expired (slice_expired)
  );

  hold_arb_ctrl #(.N_MST(N_MST), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_req       (mst_req),
    .yield_ack     (yield_ack),
    .slice_expired (slice_expired),
    .pick_found    (pick_found),
    .pick_idx      (pick_idx),
    .pick_req      (pick_req),
    .owner         (owner),
    .owned         (owned),
    .restart       (restart),
    .handoff_start (handoff_start),
    .handoff_done  (handoff_done),
    .idle_grant    (idle_grant),
    .yield_req     (yield_req),
    .bus_grant     (bus_grant)
  );

endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk #(
  parameter int N_MST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] mst_req,
  input logic [N_MST-1:0] yield_ack,
  input logic [N_MST-1:0] yield_req,
  input logic [N_MST-1:0] bus_grant,
  input logic             handoff_start,
  input logic             handoff_done
);

  a_r8_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant));

  a_r8_onehot_yield: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(yield_req));

  a_r8_no_grant_in_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (|yield_req) |-> (bus_grant == '0));

  a_r5_yield_to_owner: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_start |=> (yield_req == $past(bus_grant)));

  a_r6_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    handoff_done |-> (|(yield_req & yield_ack)));

  a_r6_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((|yield_req) && !(|(yield_req & yield_ack))) |=>
      ((yield_req == $past(yield_req)) && (bus_grant == '0)));

  a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bus_grant) && !(|(mst_req & ~bus_grant))) |=>
      (bus_grant == $past(bus_grant)));

  a_r2_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_grant == '0) && (yield_req == '0) && (|mst_req)) |=>
      ((|bus_grant) && (yield_req == '0)));

endmodule

bind hold_arbiter hold_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mst_req       (mst_req),
  .yield_ack     (yield_ack),
  .yield_req     (yield_req),
  .bus_grant     (bus_grant),
  .handoff_start (handoff_start),
  .handoff_done  (handoff_done)
);

// File: tb/sim_hold_arbiter.sv
`timescale 1ns/1ps
module sim_hold_arbiter;

  localparam int N = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  mst_req = '0;
  logic [N-1:0]  yield_ack = '0;
  logic [SW-1:0] slice_limit = '0;
  logic [N-1:0]  yield_req;
  logic [N-1:0]  bus_grant;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hold_arbiter #(.N_MST(N), .SLICE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .yield_ack(yield_ack),
    .slice_limit(slice_limit), .yield_req(yield_req), .bus_grant(bus_grant)
  );

  function automatic logic [N-1:0] bit_of(input int i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  task automatic expect_out(input string tag, input logic [N-1:0] g_exp,
                            input logic [N-1:0] y_exp);
    n_cmp++;
    if (bus_grant !== g_exp || yield_req !== y_exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b yield=%b expected grant=%b yield=%b",
               tag, bus_grant, yield_req, g_exp, y_exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mst_req = '0;
    yield_ack = '0;
    slice_limit = 8'd3;
    repeat (3) @(negedge clk);
    expect_out("R1 during reset", '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after reset", '0, '0);
  endtask

  // first request from an unowned bus, then parking
  task automatic t_first_grant();
    mst_req = 4'b0100;
    @(negedge clk);
    expect_out("R2 first grant without yield", 4'b0100, '0);
    mst_req = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expect_out("R4 parked with request low", 4'b0100, '0);
    end
  endtask

  // contender arrives while the owner is idle
  task automatic t_on_demand();
    mst_req = 4'b0001;
    @(negedge clk);
    expect_out("R5 yield raised on owner", '0, 4'b0100);
    yield_ack = 4'b0001;
    @(negedge clk);
    expect_out("R6 foreign ack ignored", '0, 4'b0100);
    yield_ack = '0;
    @(negedge clk);
    expect_out("R6 no grant before ack", '0, 4'b0100);
    yield_ack = 4'b0100;
    @(negedge clk);
    expect_out("R6 grant after owner ack", 4'b0001, '0);
    yield_ack = '0;
  endtask

  // all masters request; owner 0 in first cycle of its grant
  task automatic t_slice(input int lim, input int first_owner);
    int o;
    o = first_owner;
    slice_limit = SW'(lim);
    mst_req = 4'b1111;
    for (int r = 0; r < N; r++) begin
      for (int k = 1; k <= lim; k++) begin
        @(negedge clk);
        expect_out("R7 owner keeps slice", bit_of(o), '0);
      end
      @(negedge clk);
      expect_out("R7 yield at slice end", '0, bit_of(o));
      yield_ack = bit_of(o);
      @(negedge clk);
      o = (o + 1) % N;
      expect_out("R3 round-robin successor", bit_of(o), '0);
      yield_ack = '0;
    end
  endtask

  // contenders withdraw before the acknowledge
  task automatic t_cancel();
    slice_limit = 8'd5;
    mst_req = 4'b0010;
    @(negedge clk);
    expect_out("R5 yield on idle owner", '0, 4'b0001);
    mst_req = '0;
    @(negedge clk);
    expect_out("R6 still waiting", '0, 4'b0001);
    yield_ack = 4'b0001;
    @(negedge clk);
    expect_out("R9 bus left unowned", '0, '0);
    yield_ack = '0;
    mst_req = 4'b1000;
    @(negedge clk);
    expect_out("R2 grant from free bus", 4'b1000, '0);
    slice_limit = 8'd0;
    mst_req = 4'b1001;
    @(negedge clk);
    expect_out("R7 zero slice yields at once", '0, 4'b1000);
    mst_req = 4'b1000;
    yield_ack = 4'b1000;
    @(negedge clk);
    expect_out("R9 owner regranted", 4'b1000, '0);
    yield_ack = '0;
    mst_req = 4'b0011;
    @(negedge clk);
    expect_out("R5 yield before rotation", '0, 4'b1000);
    yield_ack = 4'b1000;
    @(negedge clk);
    expect_out("R3 wrap to master 0", 4'b0001, '0);
    yield_ack = '0;
    mst_req = '0;
  endtask

  initial begin
    t_reset();
    t_first_grant();
    t_on_demand();
    t_slice(3, 0);
    t_slice(0, 0);
    t_cancel();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule